// File: doc/BRIEF.md
# PWM Output Action Qualifier with Continuous Force

This block turns time-base events into two PWM output levels, A and B. A counter outside the block raises one-cycle strobes when it reaches zero, when it reaches the period, and when it passes compare A or compare B while counting up. Each output has a 16-bit action word that gives every relevant event a 2-bit code: leave the level, drive it low, drive it high, or invert it. A typical setup drives the output high at zero and at period and low at its compare match. Swapping high and low in those three codes gives the inverted waveform.

A continuous software force sits above the event actions. Software writes a force word, which acts as a shadow. A 2-bit reload selector, in bits 7:6 of a separate reload word, decides when that shadow is copied into the active force register: at zero, at period, at either of them, or on every clock. While an output's active force field says low or high, events cannot move that output. When the force is released, the output keeps its level until the next event action changes it. All inputs are plain control pins with no handshake, because events and settings are sampled on every clock edge.

Top module: `pwm_action_qualifier`

## Requirements
- R1: While rst_n is low, both outputs are low and the active force register holds all zeros (forcing off).
- R2: Bits 1:0 of an output's action word give the action applied when evt_zero is high.
- R3: Bits 3:2 of an output's action word give the action applied when evt_period is high.
- R4: Bits 5:4 of act_word_a act on output A when evt_cmpa_up is high. Bits 9:8 of act_word_b act on output B when evt_cmpb_up is high. A compare strobe has no effect on the other output.
- R5: Action codes are 00 keep the level, 01 low, 10 high and 11 invert. With no event and no active force, an output holds its level.
- R6: When several events with non-00 codes arrive in one cycle, only one is applied. The compare code wins over the period code, and the period code wins over the zero code.
- R7: Force word bits 1:0 control A and bits 3:2 control B. A field of 01 forces the output low and 10 forces it high, overriding every event. A field of 00 or 11 leaves the events in control.
- R8: Reload word bits 7:6 pick when the force word is copied to the active register: 00 on evt_zero, 01 on evt_period, 10 on either, 11 on every clock. Changes to the force word have no effect until such a copy happens.
- R9: The outputs are registered. An event or a copied force takes effect at the clock edge that samples it, so in immediate mode a new force value drives the output after the next edge.
- R10: After a force is released, the output keeps its forced level until an event action changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_zero | input | 1 | Counter-at-zero strobe |
| evt_period | input | 1 | Counter-at-period strobe |
| evt_cmpa_up | input | 1 | Compare A match while counting up |
| evt_cmpb_up | input | 1 | Compare B match while counting up |
| act_word_a | input | 16 | Action word for output A |
| act_word_b | input | 16 | Action word for output B |
| frc_word | input | 16 | Continuous force shadow (A at 1:0, B at 3:2) |
| rld_word | input | 16 | Force reload selector in bits 7:6 |
| out_a | output | 1 | PWM level A |
| out_b | output | 1 | PWM level B |

## Verification
A wrong active force value shows up at the outputs on the same edge it is loaded. The output either stays pinned against an event that should move it, or moves when it should be held, so a per-cycle comparison with a reference model catches it one cycle after the load. A bad priority choice or a bad toggle shows up as a wrong level right after the coincident event. A bad toggle also stays wrong until a non-toggle action overwrites it, which makes it easy to see in the long random phase. Shadow reload faults only appear when the selected event occurs, so the directed part walks through all four reload choices with distinct force values.

// File: rtl/pwmaq_pkg.sv
package pwmaq_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    RLD_ZERO   = 2'b00,
    RLD_PERIOD = 2'b01,
    RLD_EITHER = 2'b10,
    RLD_NOW    = 2'b11
  } rld_e;

  localparam int FRC_FIELD_W = 2;

  function automatic logic next_level(input act_e a, input logic cur);
    case (a)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/aq_event_select.sv
module aq_event_select
  import pwmaq_pkg::*;
(
  input  logic evt_zero,
  input  logic evt_period,
  input  logic evt_cmp,
  input  act_e zero_code,
  input  act_e prd_code,
  input  act_e cmp_code,
  output act_e win_code
);
  // Later assignments overrule earlier ones: zero < period < compare.
  always_comb begin
    win_code = ACT_NONE;
    if (evt_zero && zero_code != ACT_NONE)  win_code = zero_code;
    if (evt_period && prd_code != ACT_NONE) win_code = prd_code;
    if (evt_cmp && cmp_code != ACT_NONE)    win_code = cmp_code;
  end
endmodule

// File: rtl/aq_force_reload.sv
module aq_force_reload
  import pwmaq_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int FW = NUM_CH * FRC_FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_zero,
  input  logic          evt_period,
  input  rld_e          mode,
  input  logic [FW-1:0] shadow,
  output logic [FW-1:0] eff,
  output logic [FW-1:0] active
);
  logic load;

  always_comb begin
    case (mode)
      RLD_ZERO:   load = evt_zero;
      RLD_PERIOD: load = evt_period;
      RLD_EITHER: load = evt_zero | evt_period;
      default:    load = 1'b1;
    endcase
  end

  // Value that governs the outputs at this edge.
  assign eff = load ? shadow : active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= '0;
    else        active <= eff;
  end
endmodule

// File: rtl/aq_output_cell.sv
module aq_output_cell
  import pwmaq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  act_e                   ev_act,
  input  logic [FRC_FIELD_W-1:0] frc,
  output logic                   level
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              level <= 1'b0;
    else if (frc == 2'b01)   level <= 1'b0;
    else if (frc == 2'b10)   level <= 1'b1;
    else                     level <= next_level(ev_act, level);
  end
endmodule

// File: rtl/pwm_action_qualifier.sv
module pwm_action_qualifier
  import pwmaq_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int ZERO_LSB = 0,
  parameter int PRD_LSB  = 2,
  parameter int CMPA_LSB = 4,
  parameter int CMPB_LSB = 8,
  parameter int RLD_LSB  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_zero,
  input  logic              evt_period,
  input  logic              evt_cmpa_up,
  input  logic              evt_cmpb_up,
  input  logic [WORD_W-1:0] act_word_a,
  input  logic [WORD_W-1:0] act_word_b,
  input  logic [WORD_W-1:0] frc_word,
  input  logic [WORD_W-1:0] rld_word,
  output logic              out_a,
  output logic              out_b
);
  localparam int NUM_CH = 2;
  localparam int FW     = NUM_CH * FRC_FIELD_W;

  logic [NUM_CH-1:0][WORD_W-1:0] act_words;
  logic [NUM_CH-1:0]             evt_cmp;
  logic [NUM_CH-1:0]             lvl;
  logic [FW-1:0]                 frc_eff;
  logic [FW-1:0]                 frc_act;
  logic                          unused_bits;

  assign act_words   = {act_word_b, act_word_a};
  assign evt_cmp     = {evt_cmpb_up, evt_cmpa_up};
  assign unused_bits = ^{act_word_a, act_word_b, frc_word, rld_word};

  aq_force_reload #(.NUM_CH(NUM_CH)) u_reload (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_zero   (evt_zero),
    .evt_period (evt_period),
    .mode       (rld_e'(rld_word[RLD_LSB +: 2])),
    .shadow     (frc_word[FW-1:0]),
    .eff        (frc_eff),
    .active     (frc_act)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int CMP_LSB = (ch == 0) ? CMPA_LSB : CMPB_LSB;
    act_e win;

    aq_event_select u_sel (
      .evt_zero   (evt_zero),
      .evt_period (evt_period),
      .evt_cmp    (evt_cmp[ch]),
      .zero_code  (act_e'(act_words[ch][ZERO_LSB +: 2])),
      .prd_code   (act_e'(act_words[ch][PRD_LSB +: 2])),
      .cmp_code   (act_e'(act_words[ch][CMP_LSB +: 2])),
      .win_code   (win)
    );

    aq_output_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_act (win),
      .frc    (frc_eff[ch*FRC_FIELD_W +: FRC_FIELD_W]),
      .level  (lvl[ch])
    );
  end

  assign out_a = lvl[0];
  assign out_b = lvl[1];
endmodule

// File: rtl/pwmaq_chk.sv
module pwmaq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        evt_zero,
  input logic        evt_period,
  input logic        evt_cmpa_up,
  input logic [15:0] act_word_a,
  input logic [15:0] rld_word,
  input logic [3:0]  frc_act,
  input logic        out_a,
  input logic        out_b
);
  // R1
  rst_low_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_a && !out_b && frc_act == 4'b0000));

  // R7
  frc_a_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_act[1:0] == 2'b10) |-> out_a);

  // R7
  frc_b_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_act[3:2] == 2'b01) |-> !out_b);

  // R8
  frc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_zero && !evt_period && rld_word[7:6] == 2'b00) |=> $stable(frc_act));

  // R5
  quiet_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_zero && !evt_period && !evt_cmpa_up && rld_word[7:6] != 2'b11 &&
     (frc_act[1:0] == 2'b00 || frc_act[1:0] == 2'b11)) |=> $stable(out_a));

  // R2
  zero_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_zero && !evt_period && !evt_cmpa_up && act_word_a[1:0] == 2'b10 &&
     rld_word[7:6] == 2'b01 && (frc_act[1:0] == 2'b00 || frc_act[1:0] == 2'b11))
    |=> out_a);

  // R6
  cmp_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_cmpa_up && act_word_a[5:4] == 2'b01 && rld_word[7:6] == 2'b01 &&
     !evt_period && (frc_act[1:0] == 2'b00 || frc_act[1:0] == 2'b11))
    |=> !out_a);
endmodule

bind pwm_action_qualifier pwmaq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_zero    (evt_zero),
  .evt_period  (evt_period),
  .evt_cmpa_up (evt_cmpa_up),
  .act_word_a  (act_word_a),
  .rld_word    (rld_word),
  .frc_act     (frc_act),
  .out_a       (out_a),
  .out_b       (out_b)
);

// File: tb/pwm_action_qualifier_bench.sv
`timescale 1ns/1ps
module pwm_action_qualifier_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_z = 0, ev_p = 0, ev_ca = 0, ev_cb = 0;
  logic [15:0] act_a = 16'h0, act_b = 16'h0, frc = 16'h0, rld = 16'h0;
  logic out_a, out_b;

  int n_cmp = 0;
  int n_fail = 0;
  string tag = "R1";

  int m_out [2];
  int m_frc [2];

  always #4 clk = ~clk;

  pwm_action_qualifier u_pwm_action_qualifier (
    .clk(clk), .rst_n(rst_n),
    .evt_zero(ev_z), .evt_period(ev_p), .evt_cmpa_up(ev_ca), .evt_cmpb_up(ev_cb),
    .act_word_a(act_a), .act_word_b(act_b), .frc_word(frc), .rld_word(rld),
    .out_a(out_a), .out_b(out_b)
  );

  // Behavioural reference: one update per rising edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out[0] = 0; m_out[1] = 0; m_frc[0] = 0; m_frc[1] = 0;
    end else begin
      int sel;
      bit ld;
      sel = int'(rld[7:6]);
      ld = (sel == 0 && ev_z) || (sel == 1 && ev_p) || (sel == 2 && (ev_z || ev_p)) || sel == 3;
      if (ld) begin
        m_frc[0] = int'(frc[1:0]);
        m_frc[1] = int'(frc[3:2]);
      end
      for (int ch = 0; ch < 2; ch++) begin
        logic [15:0] w;
        bit ce;
        int code;
        w  = (ch == 0) ? act_a : act_b;
        ce = (ch == 0) ? ev_ca : ev_cb;
        code = 0;
        if (m_frc[ch] == 1) m_out[ch] = 0;
        else if (m_frc[ch] == 2) m_out[ch] = 1;
        else begin
          if (ce) code = (ch == 0) ? int'(w[5:4]) : int'(w[9:8]);
          if (code == 0 && ev_p) code = int'(w[3:2]);
          if (code == 0 && ev_z) code = int'(w[1:0]);
          if (code == 1) m_out[ch] = 0;
          else if (code == 2) m_out[ch] = 1;
          else if (code == 3) m_out[ch] = 1 - m_out[ch];
        end
      end
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (out_a !== m_out[0][0] || out_b !== m_out[1][0]) begin
        n_fail++;
        $display("FAIL %s model: got a=%b b=%b expected a=%0d b=%0d at %0t",
                 tag, out_a, out_b, m_out[0], m_out[1], $time);
      end
    end
  end

  task automatic chk(input bit ea, input bit eb, input string req);
    n_cmp++;
    if (out_a !== ea || out_b !== eb) begin
      n_fail++;
      $display("FAIL %s: got a=%b b=%b expected a=%b b=%b at %0t",
               req, out_a, out_b, ea, eb, $time);
    end
  endtask

  task automatic pulse(input bit z, input bit p, input bit ca, input bit cb);
    @(negedge clk);
    ev_z = z; ev_p = p; ev_ca = ca; ev_cb = cb;
    @(negedge clk);
    ev_z = 0; ev_p = 0; ev_ca = 0; ev_cb = 0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    act_a = 16'h001A;  // R2 R3 R4: zero high, period high, cmpA low
    act_b = 16'h0205;  // inverted: zero low, period low, cmpB high
    repeat (3) @(negedge clk);
    chk(0, 0, "R1");
    rst_n = 1'b1;
    tick(); tick();
    chk(0, 0, "R1");

    tag = "R2"; pulse(1, 0, 0, 0); chk(1, 0, "R2");
    tag = "R4"; pulse(0, 0, 1, 0); chk(0, 0, "R4");
    pulse(0, 0, 0, 1); chk(0, 1, "R4");
    tag = "R3"; pulse(0, 1, 0, 0); chk(1, 0, "R3");

    tag = "R5";
    act_a = 16'h0003; act_b = 16'h0000;
    pulse(1, 0, 0, 0); chk(0, 0, "R5");
    pulse(1, 0, 0, 0); chk(1, 0, "R5");
    act_a = 16'h0000;
    pulse(1, 1, 1, 1); chk(1, 0, "R5");

    tag = "R6";
    act_a = 16'h001B; pulse(1, 1, 1, 0); chk(0, 0, "R6");
    act_a = 16'h0009; pulse(1, 1, 1, 0); chk(1, 0, "R6");
    act_a = 16'h0001; pulse(1, 1, 0, 0); chk(0, 0, "R6");

    tag = "R7";
    rld = 16'h00C0; frc = 16'h0002;
    tick(); chk(1, 0, "R9");
    act_a = 16'h0010; pulse(0, 0, 1, 0); chk(1, 0, "R7");
    frc = 16'h000A; tick(); chk(1, 1, "R7");
    tag = "R10";
    frc = 16'h000B; tick(); chk(1, 1, "R10");
    pulse(0, 0, 1, 0); chk(0, 1, "R10");
    frc = 16'h0000; tick(); chk(0, 1, "R10");

    tag = "R8";
    act_a = 16'h0; act_b = 16'h0; rld = 16'h0000; frc = 16'h0006;
    tick(); tick(); chk(0, 1, "R8");
    pulse(0, 1, 0, 0); chk(0, 1, "R8");
    pulse(1, 0, 0, 0); chk(1, 0, "R8");
    rld = 16'h0040; frc = 16'h0009;
    pulse(1, 0, 0, 0); chk(1, 0, "R8");
    pulse(0, 1, 0, 0); chk(0, 1, "R8");
    rld = 16'h0080; frc = 16'h0006;
    pulse(1, 0, 0, 0); chk(1, 0, "R8");
    frc = 16'h0009;
    pulse(0, 1, 0, 0); chk(0, 1, "R8");
    frc = 16'h0000; rld = 16'h00C0;
    tick(); chk(0, 1, "R10");

    tag = "R9 random";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      ev_z  = ($urandom_range(0, 7) == 0);
      ev_p  = ($urandom_range(0, 7) == 0);
      ev_ca = ($urandom_range(0, 3) == 0);
      ev_cb = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 15) == 0) act_a = 16'($urandom);
      if ($urandom_range(0, 15) == 0) act_b = 16'($urandom);
      if ($urandom_range(0, 31) == 0) frc = 16'($urandom);
      if ($urandom_range(0, 31) == 0) rld = 16'($urandom);
    end
    @(negedge clk);
    ev_z = 0; ev_p = 0; ev_ca = 0; ev_cb = 0;
    tick(); tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule